// File: doc/BRIEF.md
# Double-Precision Compare Unit

This unit compares two 64-bit binary64 floating-point operands and reports whether the chosen relation holds. A two-bit operation select picks one of three relations: equality, strict less-than or less-or-equal. The one-bit outcome is zero-extended to the width of an integer register. A five-bit exception vector goes with it, and in that vector only the invalid-operation bit can be set. Both outputs are registered, so a result appears one clock edge after its operands are presented.

The unit handles signed zeros, infinities, subnormals, quiet NaNs and signaling NaNs. The operation decides how NaN inputs are reported. Equality is the quiet relation and raises invalid only for a signaling NaN. The two ordered relations raise invalid for any NaN. Flag accumulation, min/max, classification and conversions belong to other units.

Top module: `fp64_compare`

## Requirements
- R1: While `rst_n` is low, `cmp_res` and `cmp_flags` read zero, whatever the inputs are.
- R2: The outputs change only on a rising clock edge. They reflect the operands and operation present just before that edge and hold their value between edges.
- R3: With `op_sel` = 2'b10 (equal) and no NaN operand, the result is 1 exactly when the values are numerically equal. +0 and -0 count as equal.
- R4: With `op_sel` = 2'b01 (less-than) and no NaN operand, the result is 1 exactly when A < B numerically. This covers mixed signs, two negative operands (larger magnitude is smaller), infinities at the extremes and subnormals. Two zeros of any sign give 0.
- R5: With `op_sel` = 2'b00 (less-or-equal) and no NaN operand, the result is 1 exactly when A < B or A equals B. Two zeros of any sign give 1.
- R6: If either operand is a NaN (exponent all ones, fraction nonzero), the result is 0 for every operation.
- R7: For equal, the invalid flag is set only when an operand is a signaling NaN. A signaling NaN has the exponent all ones, fraction bit 51 clear and the fraction nonzero; 0x7FF0000000000001 is one. Quiet NaNs (fraction bit 51 set, such as 0x7FF8000000000000), alone or paired, leave the flags at 0.
- R8: For less-than and less-or-equal, the invalid flag is set whenever either operand is a NaN, quiet or signaling, in either position.
- R9: The invalid flag is bit 4 of `cmp_flags` (value 0x10). Bits 3..0 are always 0, and no flag is set for non-NaN operands.
- R10: `op_sel` = 2'b11 gives result 0 and flags 0 for any operands.
- R11: Bits XLEN-1..1 of `cmp_res` are always 0. The relation outcome sits in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 64 | Operand A, binary64 bit pattern |
| op_b | input | 64 | Operand B, binary64 bit pattern |
| op_sel | input | 2 | 00 less-or-equal, 01 less-than, 10 equal, 11 no operation |
| cmp_res | output | XLEN (64) | Zero-extended compare outcome |
| cmp_flags | output | 5 | Exception flags, bit 4 = invalid |

## Verification
The assertions check these rules on every cycle:
- a NaN forces a zero result;
- a NaN raises invalid under the ordered relations;
- equality stays silent on quiet NaNs and flags signaling ones;
- the unused flag bits and the upper result bits stay zero;
- the unused operation code has no effect;
- less-or-equal agrees with the union of the ordering and equality signals.

Only the bench's scenarios can show that the numerical ordering itself is right. That means sign handling for two negatives, signed-zero equality, the ends of the range at infinity, subnormal ordering and a NaN in the B position. The bench compares each outcome against an independent model that does the comparison on real numbers.

// File: rtl/fp64_cmp_pkg.sv
package fp64_cmp_pkg;

  typedef enum logic [1:0] {
    OP_LE   = 2'b00,
    OP_LT   = 2'b01,
    OP_EQ   = 2'b10,
    OP_NONE = 2'b11
  } cmp_op_e;

  localparam int FLAG_W      = 5;
  localparam int FLAG_INV_IX = 4;

  typedef struct packed {
    logic sign;
    logic is_zero;
    logic is_nan;
    logic is_snan;
  } fp_kind_t;

endpackage

// File: rtl/fp64_classify.sv
module fp64_classify
  import fp64_cmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] val,
  output fp_kind_t              kind
);
  localparam int W = 1 + EXP_W + FRAC_W;

  function automatic fp_kind_t sort_operand(input logic [W-1:0] v);
    fp_kind_t k;
    logic exp_max;
    logic frac_nz;
    exp_max   = &v[W-2:FRAC_W];
    frac_nz   = |v[FRAC_W-1:0];
    k.sign    = v[W-1];
    k.is_zero = ~|v[W-2:0];
    k.is_nan  = exp_max & frac_nz;
    // the top fraction bit marks a quiet NaN
    k.is_snan = exp_max & frac_nz & ~v[FRAC_W-1];
    return k;
  endfunction

  assign kind = sort_operand(val);
endmodule

// File: rtl/fp64_order.sv
module fp64_order
  import fp64_cmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] val_a,
  input  logic [EXP_W+FRAC_W:0] val_b,
  input  fp_kind_t              kind_a,
  input  fp_kind_t              kind_b,
  output logic                  ord_eq,
  output logic                  ord_lt
);
  localparam int W = 1 + EXP_W + FRAC_W;

  // Equality: identical bit patterns, or two zeros of any sign.
  function automatic logic same_value(input logic [W-1:0] a, input logic [W-1:0] b,
                                      input logic za, input logic zb);
    return (za & zb) | (a == b);
  endfunction

  // Sign-magnitude ordering; the magnitude order flips when both are negative.
  function automatic logic below(input logic [W-1:0] a, input logic [W-1:0] b,
                                 input logic za, input logic zb);
    logic [W-2:0] ma;
    logic [W-2:0] mb;
    ma = a[W-2:0];
    mb = b[W-2:0];
    if (za & zb)              return 1'b0;
    else if (a[W-1] != b[W-1]) return a[W-1];
    else if (!a[W-1])          return ma < mb;
    else                       return ma > mb;
  endfunction

  assign ord_eq = same_value(val_a, val_b, kind_a.is_zero, kind_b.is_zero);
  assign ord_lt = below(val_a, val_b, kind_a.is_zero, kind_b.is_zero);
endmodule

// File: rtl/fp64_compare.sv
module fp64_compare
  import fp64_cmp_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [EXP_W+FRAC_W:0]   op_a,
  input  logic [EXP_W+FRAC_W:0]   op_b,
  input  logic [1:0]              op_sel,
  output logic [XLEN-1:0]         cmp_res,
  output logic [FLAG_W-1:0]       cmp_flags
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int N_OPD = 2;

  logic [N_OPD-1:0][W-1:0] opnd;
  fp_kind_t                kind [N_OPD];
  logic                    ord_eq, ord_lt;
  logic                    any_nan, any_snan;
  logic                    hit_d, inv_d;
  logic                    hit_q, inv_q;
  cmp_op_e                 op;

  assign opnd[0] = op_a;
  assign opnd[1] = op_b;
  assign op      = cmp_op_e'(op_sel);

  for (genvar g = 0; g < N_OPD; g++) begin : g_kind
    fp64_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .val  (opnd[g]),
      .kind (kind[g])
    );
  end

  fp64_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_ord (
    .val_a  (op_a),
    .val_b  (op_b),
    .kind_a (kind[0]),
    .kind_b (kind[1]),
    .ord_eq (ord_eq),
    .ord_lt (ord_lt)
  );

  assign any_nan  = kind[0].is_nan  | kind[1].is_nan;
  assign any_snan = kind[0].is_snan | kind[1].is_snan;

  always_comb begin
    hit_d = 1'b0;
    inv_d = 1'b0;
    case (op)
      OP_LE: begin
        hit_d = ~any_nan & (ord_lt | ord_eq);
        inv_d = any_nan;
      end
      OP_LT: begin
        hit_d = ~any_nan & ord_lt;
        inv_d = any_nan;
      end
      OP_EQ: begin
        hit_d = ~any_nan & ord_eq;
        inv_d = any_snan;
      end
      default: begin
        hit_d = 1'b0;
        inv_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      inv_q <= 1'b0;
    end else begin
      hit_q <= hit_d;
      inv_q <= inv_d;
    end
  end

  assign cmp_res   = {{(XLEN-1){1'b0}}, hit_q};
  assign cmp_flags = FLAG_W'(inv_q) << FLAG_INV_IX;

  // ---------------- assertions ----------------
  a_r6_nan_gives_zero: assert property (@(posedge clk) disable iff (!rst_n)
    any_nan |=> cmp_res == '0);

  a_r7_eq_quiet_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_EQ && any_nan && !any_snan) |=> cmp_flags == '0);

  a_r7_eq_snan_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_EQ && any_snan) |=> cmp_flags[FLAG_INV_IX]);

  a_r8_ordered_nan_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_LT || op == OP_LE) && any_nan) |=> cmp_flags[FLAG_INV_IX]);

  a_r9_unused_flags_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_flags[FLAG_INV_IX-1:0] == '0);

  a_r9_no_flag_without_nan: assert property (@(posedge clk) disable iff (!rst_n)
    !any_nan |=> cmp_flags == '0);

  a_r10_idle_op_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NONE) |=> (cmp_res == '0 && cmp_flags == '0));

  a_r11_zero_extended: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_res[XLEN-1:1] == '0);

  a_r4_eq_lt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ord_eq && ord_lt));

  a_r5_le_union: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LE && !any_nan) |=> cmp_res[0] == $past(ord_lt || ord_eq));

endmodule

// File: tb/sim_fp64_compare.sv
module sim_fp64_compare;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [63:0]     op_a = '0;
  logic [63:0]     op_b = '0;
  logic [1:0]      op_sel = 2'b10;
  logic [XLEN-1:0] cmp_res;
  logic [4:0]      cmp_flags;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  fp64_compare #(.XLEN(XLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .op_sel(op_sel), .cmp_res(cmp_res), .cmp_flags(cmp_flags)
  );

  function automatic bit is_nan64(input logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 52'd0);
  endfunction

  function automatic bit is_snan64(input logic [63:0] v);
    return is_nan64(v) && !v[51];
  endfunction

  // Reference outcome by real-number comparison.
  function automatic logic [XLEN-1:0] ref_res(input logic [63:0] a, input logic [63:0] b,
                                              input logic [1:0] op);
    real ra, rb;
    bit  r;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    if (is_nan64(a) || is_nan64(b)) r = 1'b0;
    else case (op)
      2'b00:   r = (ra <= rb);
      2'b01:   r = (ra < rb);
      2'b10:   r = (ra == rb);
      default: r = 1'b0;
    endcase
    return XLEN'(r);
  endfunction

  function automatic logic [4:0] ref_flags(input logic [63:0] a, input logic [63:0] b,
                                           input logic [1:0] op);
    bit inv;
    case (op)
      2'b00, 2'b01: inv = is_nan64(a) || is_nan64(b);
      2'b10:        inv = is_snan64(a) || is_snan64(b);
      default:      inv = 1'b0;
    endcase
    return inv ? 5'h10 : 5'h00;
  endfunction

  function automatic string tag_for(input logic [63:0] a, input logic [63:0] b,
                                    input logic [1:0] op, input bit flag_chk);
    if (op == 2'b11) return "R10";
    if (is_nan64(a) || is_nan64(b)) begin
      if (!flag_chk) return "R6";
      return (op == 2'b10) ? "R7" : "R8";
    end
    if (flag_chk) return "R9";
    case (op)
      2'b10:   return "R3+R11";
      2'b01:   return "R4+R11";
      default: return "R5+R11";
    endcase
  endfunction

  task automatic run(input logic [63:0] a, input logic [63:0] b, input logic [1:0] op);
    logic [XLEN-1:0] er;
    logic [4:0]      ef;
    er = ref_res(a, b, op);
    ef = ref_flags(a, b, op);
    @(negedge clk);
    op_a = a; op_b = b; op_sel = op;
    @(negedge clk);
    n_checks++;
    if (cmp_res !== er) begin
      n_errors++;
      $display("FAIL %s result a=%h b=%h op=%b actual=%h expected=%h",
               tag_for(a, b, op, 1'b0), a, b, op, cmp_res, er);
    end
    n_checks++;
    if (cmp_flags !== ef) begin
      n_errors++;
      $display("FAIL %s flags a=%h b=%h op=%b actual=%h expected=%h",
               tag_for(a, b, op, 1'b1), a, b, op, cmp_flags, ef);
    end
  endtask

  task automatic run_all_ops(input logic [63:0] a, input logic [63:0] b);
    for (int o = 0; o < 4; o++) begin
      run(a, b, 2'(o));
      run(b, a, 2'(o));
    end
  endtask

  function automatic logic [63:0] special(input int k);
    case (k % 14)
      0:  return 64'h0000_0000_0000_0000;
      1:  return 64'h8000_0000_0000_0000;
      2:  return 64'h7FF0_0000_0000_0000;
      3:  return 64'hFFF0_0000_0000_0000;
      4:  return 64'h7FF8_0000_0000_0000;
      5:  return 64'h7FF0_0000_0000_0001;
      6:  return 64'hFFF4_0000_0000_0000;
      7:  return 64'h0000_0000_0000_0001;
      8:  return 64'h8000_0000_0000_0001;
      9:  return 64'h000F_FFFF_FFFF_FFFF;
      10: return 64'h7FEF_FFFF_FFFF_FFFF;
      11: return 64'hFFEF_FFFF_FFFF_FFFF;
      12: return 64'h3FF0_0000_0000_0000;
      default: return 64'hBFF0_0000_0000_0000;
    endcase
  endfunction

  function automatic logic [63:0] rand_opnd();
    int k;
    k = int'($urandom % 6);
    case (k)
      0, 1: return {$urandom, $urandom};
      2:    return special(int'($urandom % 14));
      3:    return {1'($urandom), 11'd0, 20'($urandom), $urandom};
      4:    return {1'($urandom), 11'h3FF - 11'($urandom % 4), 20'($urandom), $urandom};
      default: return {1'($urandom), 11'h7FF, 20'($urandom), $urandom};
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin : main
    logic [63:0] m136, m137, qn, sn;
    void'($urandom(32'd20240611));
    m136 = $realtobits(-1.36);
    m137 = $realtobits(-1.37);
    qn   = 64'h7FF8_0000_0000_0000;
    sn   = 64'h7FF0_0000_0000_0001;

    // R1: outputs stay zero under reset with an input that would give 1
    op_a = m136; op_b = m136; op_sel = 2'b10;
    repeat (3) @(negedge clk);
    n_checks++;
    if (cmp_res !== '0 || cmp_flags !== '0) begin
      n_errors++;
      $display("FAIL R1 reset actual=%h/%h expected=0/0", cmp_res, cmp_flags);
    end
    rst_n = 1'b1;

    // R2: output holds between edges, updates after the edge
    run(m136, m136, 2'b10);
    @(negedge clk);
    op_a = m137; op_b = m136; op_sel = 2'b10;
    #1;
    n_checks++;
    if (cmp_res !== 64'd1) begin
      n_errors++;
      $display("FAIL R2 hold before edge actual=%h expected=%h", cmp_res, 64'd1);
    end
    @(negedge clk);
    n_checks++;
    if (cmp_res !== 64'd0) begin
      n_errors++;
      $display("FAIL R2 update after edge actual=%h expected=%h", cmp_res, 64'd0);
    end

    // Equal and less pairs, all ops (R3 R4 R5)
    run_all_ops(m136, m136);
    run_all_ops(m137, m136);
    // Signed zeros (R3), infinities and extremes (R4), subnormals (R5)
    run_all_ops(64'h0, 64'h8000_0000_0000_0000);
    run_all_ops(64'h7FF0_0000_0000_0000, 64'h7FEF_FFFF_FFFF_FFFF);
    run_all_ops(64'hFFF0_0000_0000_0000, 64'hFFEF_FFFF_FFFF_FFFF);
    run_all_ops(64'hFFF0_0000_0000_0000, 64'h7FF0_0000_0000_0000);
    run_all_ops(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002);
    run_all_ops(64'h8000_0000_0000_0001, 64'h8000_0000_0000_0002);
    // NaNs in both positions (R6 R7 R8)
    run_all_ops(qn, 64'h0);
    run_all_ops(qn, qn);
    run_all_ops(sn, 64'h0);
    run_all_ops(sn, qn);
    run_all_ops(64'hFFF4_0000_0000_0000, m136);
    // Unused opcode (R10)
    run(64'h0, 64'h0, 2'b11);
    run(sn, 64'h0, 2'b11);

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a, b;
      int sel;
      a = rand_opnd();
      sel = int'($urandom % 8);
      if (sel == 0)      b = a;
      else if (sel == 1) b = {~a[63], a[62:0]};
      else               b = rand_opnd();
      run(a, b, 2'($urandom % 4));
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule